// File: doc/BRIEF.md
# DDR2 Bank Timing Command Scheduler

This block sits on the controller side of a four-bank DDR2 memory. It takes one read or write request at a time from an upstream requester, with a bank, row and column, and turns it into a sequence of memory commands. A request to a row that is already open goes straight to a column command. A request to a closed bank opens the row first. A request to a different row in an open bank closes that bank, opens the new row, and then issues the column command. The requester holds the request until a one-cycle grant appears on the same cycle as the column command.

The minimum spacing rules between commands are given as times in picoseconds, along with the clock period. At elaboration each one is converted to a whole number of cycles, rounded up. The block tracks, for every bank, whether a row is open and which row it is, and keeps countdowns for activate-to-column, precharge-to-activate, activate-to-activate, and the minimum row-active time. It also counts how long each row has been open, so that it can force a precharge before the maximum row-active time runs out. A free-running interval timer requests a refresh. The refresh is issued only when all banks are closed and the precharge time has passed, and it then blocks activates for the refresh recovery time.

Commands leave on a registered bus made of active-low chip select, row strobe, column strobe and write enable, plus the bank and address lines.

Top module: `ddr2_bank_sched`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the command bus is deselected (chip select high) and the grant is low. All banks start closed, so the first request to any bank produces an activate before its column command.
- R2: Each command is encoded on {cs_n, ras_n, cas_n, we_n} as follows: activate 0011, read 0101, write 0100, precharge 0010, refresh 0001. Idle cycles drive 1111. No other pattern with cs_n low ever appears.
- R3: A read or write to a bank comes at least ceil(T_RCD_PS/CLK_PS) cycles after the activate of that bank.
- R4: An activate to a bank, and any refresh, comes at least ceil(T_RP_PS/CLK_PS) cycles after the last precharge that covered that bank (or any bank, for refresh).
- R5: Two activates to the same bank are at least ceil(T_RC_PS/CLK_PS) cycles apart.
- R6: A precharge, single-bank or all-bank, closes an open bank no sooner than ceil(T_RAS_PS/CLK_PS) cycles after that bank's activate.
- R7: A request that hits the open row of its bank is served with a column command alone, with no precharge or activate. The grant is high only on cycles that carry a read or write.
- R8: A request to a closed bank issues one activate and then the column command. A request to another row of an open bank first issues a single-bank precharge (address bit 10 low, BA = bank), then one activate, then the column command.
- R9: A refresh is issued only when all banks are closed. The k-th refresh after reset comes no later than k*ceil(T_REFI_PS/CLK_PS) plus a small fixed number of cycles.
- R10: When a refresh falls due while rows are open, all of them are closed by one precharge with address bit 10 high.
- R11: No row stays open for ceil(T_RAS_MAX_PS/CLK_PS) cycles or more. A row left idle is closed by a forced single-bank precharge.
- R12: No activate is issued within ceil(T_RFC_PS/CLK_PS) cycles after a refresh.
- R13: A column command carries the request's bank on BA, the column on address bits [COL_W-1:0], and address bit 10 low. It is a write exactly when the request is a write (we_n low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until granted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_grant | output | 1 | One-cycle pulse with the column command |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | ADDR_W | Row, column or precharge-scope address |

## Verification
The bench builds the scheduler with a 10 ns clock period, a 400 ns maximum row-active time and a 3 us refresh interval. These give activate-to-column and precharge times of 2 cycles, a row cycle of 6, a minimum row-active time of 4, refresh recovery of 11, a forced close at 40 cycles and a refresh every 300 cycles. With these values, forced closes, all-bank precharges before refresh, and several refreshes all fit in a short run. A sweep over every bank, with row misses, row hits, closed banks, reads and writes, is checked command by command against per-bank timestamps kept in the bench.

// File: rtl/ddr2_bank_sched.sv
module ddr2_bank_sched #(
  parameter int CLK_PS       = 2500,
  parameter int T_RCD_PS     = 12500,
  parameter int T_RP_PS      = 12500,
  parameter int T_RC_PS      = 57500,
  parameter int T_RAS_PS     = 40000,
  parameter int T_RAS_MAX_PS = 70000000,
  parameter int T_REFI_PS    = 7800000,
  parameter int T_RFC_PS     = 105000,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int ADDR_W       = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_grant,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);

  function automatic int to_cyc(int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RCD_CYC    = to_cyc(T_RCD_PS);
  localparam int RP_CYC     = to_cyc(T_RP_PS);
  localparam int RC_CYC     = to_cyc(T_RC_PS);
  localparam int RAS_CYC    = to_cyc(T_RAS_PS);
  localparam int RASMAX_CYC = to_cyc(T_RAS_MAX_PS);
  localparam int REFI_CYC   = to_cyc(T_REFI_PS);
  localparam int RFC_CYC    = to_cyc(T_RFC_PS);
  localparam int RAS_GUARD  = 4;
  localparam int RAS_CLOSE  = RASMAX_CYC - RAS_GUARD;
  localparam int TW = $clog2(RCD_CYC + RP_CYC + RC_CYC + RAS_CYC + RFC_CYC + 1);
  localparam int AW = $clog2(RASMAX_CYC + 1);
  localparam int FW = $clog2(REFI_CYC + 1);

  typedef enum logic [2:0] {C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_PREA, C_REF} cmd_e;

  logic [3:0]       open_q;
  logic [ROW_W-1:0] row_q [4];
  logic [TW-1:0]    rcd_q [4];
  logic [TW-1:0]    ras_q [4];
  logic [TW-1:0]    rc_q  [4];
  logic [TW-1:0]    rp_q  [4];
  logic [AW-1:0]    age_q [4];
  logic [TW-1:0]    rfc_q;
  logic [FW-1:0]    refi_q;
  logic             ref_pend;

  cmd_e       nxt;
  logic [1:0] nba;
  logic       force_pre;
  logic [1:0] force_ba;
  logic       ras_ok_all, rp_ok_all;

  always_comb begin
    force_pre  = 1'b0;
    force_ba   = 2'd0;
    ras_ok_all = 1'b1;
    rp_ok_all  = 1'b1;
    for (int b = 3; b >= 0; b--) begin
      if (open_q[b] && age_q[b] >= AW'(RAS_CLOSE)) begin
        force_pre = 1'b1;
        force_ba  = 2'(b);
      end
      if (open_q[b] && ras_q[b] != '0) ras_ok_all = 1'b0;
      if (rp_q[b] != '0) rp_ok_all = 1'b0;
    end
  end

  always_comb begin
    nxt = C_NONE;
    nba = req_bank;
    if (force_pre) begin
      nxt = C_PRE;
      nba = force_ba;
    end else if (ref_pend) begin
      if (|open_q) begin
        if (ras_ok_all) nxt = C_PREA;
      end else if (rp_ok_all && rfc_q == '0) begin
        nxt = C_REF;
      end
    end else if (req_valid) begin
      if (open_q[req_bank]) begin
        if (row_q[req_bank] == req_row) begin
          if (rcd_q[req_bank] == '0) nxt = req_write ? C_WR : C_RD;
        end else if (ras_q[req_bank] == '0) begin
          nxt = C_PRE;
        end
      end else if (rp_q[req_bank] == '0 && rc_q[req_bank] == '0 && rfc_q == '0) begin
        nxt = C_ACT;
      end
    end
  end

  logic [3:0]        enc;
  logic [ADDR_W-1:0] nxt_addr;

  always_comb begin
    nxt_addr = '0;
    unique case (nxt)
      C_ACT:   begin enc = 4'b0011; nxt_addr = ADDR_W'(req_row); end
      C_RD:    begin enc = 4'b0101; nxt_addr = ADDR_W'(req_col); end
      C_WR:    begin enc = 4'b0100; nxt_addr = ADDR_W'(req_col); end
      C_PRE:   enc = 4'b0010;
      C_PREA:  begin enc = 4'b0010; nxt_addr[10] = 1'b1; end
      C_REF:   enc = 4'b0001;
      default: enc = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= '0;
      rfc_q    <= '0;
      refi_q   <= '0;
      ref_pend <= 1'b0;
      for (int b = 0; b < 4; b++) begin
        row_q[b] <= '0;
        rcd_q[b] <= '0;
        ras_q[b] <= '0;
        rc_q[b]  <= '0;
        rp_q[b]  <= '0;
        age_q[b] <= '0;
      end
      {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= 4'b1111;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      req_grant <= 1'b0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
        if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
        if (rc_q[b]  != '0) rc_q[b]  <= rc_q[b]  - 1'b1;
        if (rp_q[b]  != '0) rp_q[b]  <= rp_q[b]  - 1'b1;
        if (open_q[b] && age_q[b] != AW'(RASMAX_CYC)) age_q[b] <= age_q[b] + 1'b1;
      end
      if (rfc_q != '0) rfc_q <= rfc_q - 1'b1;

      case (nxt)
        C_ACT: begin
          open_q[nba] <= 1'b1;
          row_q[nba]  <= req_row;
          rcd_q[nba]  <= TW'(RCD_CYC - 1);
          ras_q[nba]  <= TW'(RAS_CYC - 1);
          rc_q[nba]   <= TW'(RC_CYC - 1);
          age_q[nba]  <= '0;
        end
        C_PRE: begin
          open_q[nba] <= 1'b0;
          rp_q[nba]   <= TW'(RP_CYC - 1);
        end
        C_PREA: begin
          open_q <= '0;
          for (int b = 0; b < 4; b++) rp_q[b] <= TW'(RP_CYC - 1);
        end
        C_REF: begin
          rfc_q    <= TW'(RFC_CYC - 1);
          ref_pend <= 1'b0;
        end
        default: ;
      endcase

      if (refi_q == FW'(REFI_CYC - 1)) begin
        refi_q   <= '0;
        ref_pend <= 1'b1;
      end else begin
        refi_q <= refi_q + 1'b1;
      end

      {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= enc;
      cmd_ba    <= nba;
      cmd_addr  <= nxt_addr;
      req_grant <= (nxt == C_RD) || (nxt == C_WR);
    end
  end

endmodule

// File: rtl/ddr2_bank_sched_chk.sv
module ddr2_bank_sched_chk #(
  parameter int RCD_CYC = 1,
  parameter int RP_CYC  = 1,
  parameter int RAS_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_grant,
  input logic       cmd_cs_n,
  input logic       cmd_ras_n,
  input logic       cmd_cas_n,
  input logic       cmd_we_n,
  input logic [1:0] cmd_ba,
  input logic       cmd_a10
);
  logic [15:0] since_act [4];
  logic [15:0] since_pre [4];

  wire is_act = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && cmd_we_n;
  wire is_col = !cmd_cs_n && cmd_ras_n && !cmd_cas_n;
  wire is_pre = !cmd_cs_n && !cmd_ras_n && cmd_cas_n && !cmd_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin
        since_act[b] <= 16'hFFFF;
        since_pre[b] <= 16'hFFFF;
      end
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (is_act && cmd_ba == 2'(b)) since_act[b] <= 16'd1;
        else if (since_act[b] != 16'hFFFF) since_act[b] <= since_act[b] + 16'd1;
        if (is_pre && (cmd_a10 || cmd_ba == 2'(b))) since_pre[b] <= 16'd1;
        else if (since_pre[b] != 16'hFFFF) since_pre[b] <= since_pre[b] + 16'd1;
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (cmd_cs_n && !req_grant)); // R1
  AST_GRANT_COL: assert property (@(posedge clk) disable iff (!rst_n) req_grant |-> is_col); // R7
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n) is_col |-> since_act[cmd_ba] >= 16'(RCD_CYC)); // R3
  AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n) is_act |-> since_pre[cmd_ba] >= 16'(RP_CYC)); // R4
  AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n) (is_pre && !cmd_a10) |-> since_act[cmd_ba] >= 16'(RAS_CYC)); // R6
endmodule

bind ddr2_bank_sched ddr2_bank_sched_chk #(
  .RCD_CYC(RCD_CYC), .RP_CYC(RP_CYC), .RAS_CYC(RAS_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_grant(req_grant),
  .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
  .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a10(cmd_addr[10])
);

// File: tb/ddr2_bank_sched_tb_top.sv
module ddr2_bank_sched_tb_top;
  localparam int CLK_PS = 10000, T_RCD = 12500, T_RP = 12500, T_RC = 57500, T_RAS = 40000;
  localparam int T_RASMAX = 400000, T_REFI = 3000000, T_RFC = 105000;
  localparam int ROW_W = 13, COL_W = 10, ADDR_W = 14;

  function automatic int cy(int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction
  localparam int RCD = cy(T_RCD), RP = cy(T_RP), RC = cy(T_RC), RAS = cy(T_RAS);
  localparam int RASMAX = cy(T_RASMAX), REFI = cy(T_REFI), RFC = cy(T_RFC);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_grant, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0] cmd_ba;
  logic [ADDR_W-1:0] cmd_addr;

  always #5ns clk = ~clk;

  ddr2_bank_sched #(
    .CLK_PS(CLK_PS), .T_RCD_PS(T_RCD), .T_RP_PS(T_RP), .T_RC_PS(T_RC), .T_RAS_PS(T_RAS),
    .T_RAS_MAX_PS(T_RASMAX), .T_REFI_PS(T_REFI), .T_RFC_PS(T_RFC),
    .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_grant(req_grant),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit m_open [4];
  int m_row [4], t_act [4], t_pre [4];
  int t_ref = -1000, t_pre_any = -1000;
  int n_act = 0, n_prea = 0, n_ref = 0;
  int n_pre [4];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  initial for (int b = 0; b < 4; b++) begin
    m_open[b] = 0; m_row[b] = 0; t_act[b] = -1000; t_pre[b] = -1000; n_pre[b] = 0;
  end

  always @(posedge clk) begin
    #1ns;
    if (!rst_n) cyc = 0;
    else begin
      cyc++;
      chk(!req_grant || (!cmd_cs_n && cmd_ras_n && !cmd_cas_n), "R7 grant only with column", req_grant, 0);
      if (!cmd_cs_n) begin
        case ({cmd_ras_n, cmd_cas_n, cmd_we_n})
          3'b011: begin
            chk(!m_open[cmd_ba], "R8 activate to closed bank", m_open[cmd_ba], 0);
            chk(cyc - t_pre[cmd_ba] >= RP, "R4 precharge to activate", cyc - t_pre[cmd_ba], RP);
            chk(cyc - t_act[cmd_ba] >= RC, "R5 activate to activate", cyc - t_act[cmd_ba], RC);
            chk(cyc - t_ref >= RFC, "R12 refresh to activate", cyc - t_ref, RFC);
            m_open[cmd_ba] = 1; m_row[cmd_ba] = int'(cmd_addr[ROW_W-1:0]);
            t_act[cmd_ba] = cyc; n_act++;
          end
          3'b101, 3'b100: begin
            chk(m_open[cmd_ba], "R7 column to open bank", m_open[cmd_ba], 1);
            chk(cyc - t_act[cmd_ba] >= RCD, "R3 activate to column", cyc - t_act[cmd_ba], RCD);
            chk(cmd_addr[10] == 0, "R13 column A10 low", cmd_addr[10], 0);
          end
          3'b010: begin
            if (cmd_addr[10]) begin
              for (int b = 0; b < 4; b++) begin
                if (m_open[b]) chk(cyc - t_act[b] >= RAS, "R6 row active min (all)", cyc - t_act[b], RAS);
                m_open[b] = 0; t_pre[b] = cyc;
              end
              n_prea++;
            end else begin
              chk(m_open[cmd_ba], "R8 single precharge of open bank", m_open[cmd_ba], 1);
              chk(cyc - t_act[cmd_ba] >= RAS, "R6 row active min", cyc - t_act[cmd_ba], RAS);
              m_open[cmd_ba] = 0; t_pre[cmd_ba] = cyc; n_pre[cmd_ba]++;
            end
            t_pre_any = cyc;
          end
          3'b001: begin
            chk(!(m_open[0] | m_open[1] | m_open[2] | m_open[3]), "R9 refresh with banks closed", 1, 0);
            chk(cyc - t_pre_any >= RP, "R4 precharge to refresh", cyc - t_pre_any, RP);
            n_ref++;
            chk(cyc <= n_ref * REFI + 30, "R9 refresh deadline", cyc, n_ref * REFI + 30);
            t_ref = cyc;
          end
          default: chk(0, "R2 command encoding", int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), 0);
        endcase
      end else begin
        chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b111, "R2 idle encoding",
            int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), 7);
      end
      for (int b = 0; b < 4; b++)
        if (m_open[b]) chk(cyc - t_act[b] < RASMAX, "R11 row active max", cyc - t_act[b], RASMAX);
    end
  end

  always @(posedge clk) if (cyc > 20000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog at cycle %0d: actual %0d expected %0d", cyc, cyc, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic do_req(int b, int row, int col, bit wr);
    bit open0 = m_open[b];
    int row0 = m_row[b], age0 = cyc - t_act[b];
    int a0 = n_act, p0 = n_pre[b], x0 = n_prea + n_ref;
    bit got = 0;
    req_valid = 1; req_write = wr; req_bank = 2'(b);
    req_row = ROW_W'(row); req_col = COL_W'(col);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #3ns;
      if (req_grant) begin got = 1; break; end
    end
    chk(got, "R7 request granted", got, 1);
    if (got) begin
      chk(cmd_ba == 2'(b), "R13 column bank", cmd_ba, b);
      chk(int'(cmd_addr[COL_W-1:0]) == col, "R13 column address", cmd_addr[COL_W-1:0], col);
      chk(cmd_we_n == !wr, "R13 read/write kind", cmd_we_n, !wr);
      if (n_prea + n_ref == x0 && !(open0 && age0 >= 30)) begin
        if (open0 && row0 == row) begin
          chk(n_act == a0 && n_pre[b] == p0, "R7 row hit no activate/precharge", n_act - a0 + n_pre[b] - p0, 0);
        end else if (open0) begin
          chk(n_pre[b] - p0 == 1, "R8 row miss precharge count", n_pre[b] - p0, 1);
          chk(n_act - a0 == 1, "R8 row miss activate count", n_act - a0, 1);
        end else begin
          chk(n_pre[b] == p0, "R8 closed bank no precharge", n_pre[b] - p0, 0);
          chk(n_act - a0 == 1, "R1 R8 closed bank activate count", n_act - a0, 1);
        end
      end
    end
    req_valid = 0;
  endtask

  initial begin
    repeat (4) begin
      @(posedge clk); #1ns;
      chk(cmd_cs_n && !req_grant, "R1 reset idle", {cmd_cs_n, req_grant}, 2);
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #3ns;
    chk(cmd_cs_n && !req_grant, "R1 first cycle idle", {cmd_cs_n, req_grant}, 2);
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 3; r++)
        for (int rep = 0; rep < 2; rep++)
          do_req(b, r * 5 + b, (b * 37 + r * 11 + rep * 7) % 1024, 1'(rep ^ (r & 1)));
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 4; b++)
        for (int rep = 0; rep < 2; rep++)
          do_req(b, 100 + r * 3 + (b & 1), 1023 - b * 9 - r, 1'(b & 1));
    repeat (60) @(posedge clk);
    #3ns;
    chk(!(m_open[0] | m_open[1] | m_open[2] | m_open[3]), "R11 idle rows force-closed", 1, 0);
    begin
      int target = (cyc / REFI + 1) * REFI - 25;
      int p, r;
      if (target - cyc < 5) target += REFI;
      while (cyc < target) begin @(posedge clk); #3ns; end
      do_req(1, 7, 3, 0);
      do_req(2, 9, 4, 1);
      p = n_prea; r = n_ref;
      for (int i = 0; i < 200 && n_ref == r; i++) begin @(posedge clk); #3ns; end
      chk(n_ref > r, "R9 refresh issued", n_ref - r, 1);
      chk(n_prea > p, "R10 all-bank precharge before refresh", n_prea - p, 1);
    end
    while (n_ref < 4) begin @(posedge clk); #3ns; end
    chk(n_ref >= 4, "R9 refresh count", n_ref, 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule